// File: doc/BRIEF.md
# Multicycle Shared-Bus Processor Controller

A small stored-program core in which instructions and data live in one memory, reached through a single address bus and a single data bus. Each instruction walks through a fixed series of steps spread over several clock cycles: fetch, decode with register read, ALU, an optional data access, and a final retire step that writes the register file and advances the program counter. The address bus is shared through a multiplexer. During a fetch it carries the program counter. During a data access it carries a memory address register that the ALU loads.

The memory port uses a request/ready handshake, so memory may take any number of cycles to answer. The time an instruction takes therefore depends on how long memory waits, not on a fixed one-cycle rule. Three operations are supported, all in the standard 32-bit encoding: word load, word store and register-register add. Any other encoding halts the core until reset.

Top module: `mcProcCore`

## Requirements
- R1: Reset places the program counter at RESET_PC (default 0), clears all 32 registers and the halt flag, and the core then requests a fetch (write strobe low) from RESET_PC.
- R2: A fetch drives the program counter on the address bus with the write strobe low, and the word returned with ready is taken as the next instruction.
- R3: Once a request is raised it stays raised, with address, write strobe and write data unchanged, until ready is sampled high; the write strobe is raised only for store data accesses.
- R4: Opcode 0x23 in bits 31:26 is a load: address = register rs (bits 25:21) + sign-extended bits 15:0, and the returned word is written to register rt (bits 20:16); 0x8C410000 loads register 1 from the address in register 2.
- R5: Opcode 0x2B is a store: address formed as for a load, register rt is driven as write data with the write strobe high.
- R6: Opcode 0 with funct 0x20 in bits 5:0 writes rs + rt (modulo 2^32) to rd (bits 15:11); rs and rt are read in the same cycle and may name the same register.
- R7: Every completed instruction advances the program counter by 4, so fetch addresses run sequentially.
- R8: With L the number of cycles a request stays raised (ready cycle included), fetch-to-fetch time is L+3 cycles for an add and 2L+3 for a load or store.
- R9: Register 0 always reads as zero; loads and adds targeting it have no effect.
- R10: Any other opcode, or opcode 0 with funct other than 0x20, halts the core: the illegal flag rises, no further request is issued and nothing after the bad word executes, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | Write strobe, high only for store data accesses |
| memAddr | output | 32 | Byte address: program counter or memory address register |
| memWdata | output | 32 | Store data (register rt) |
| memRdata | input | 32 | Read data, valid with memReady |
| memReady | input | 1 | Memory completes the current request |
| illegal | output | 1 | Core halted on an unsupported encoding |

## Verification
On every cycle the assertions check that a pending request holds its address, strobe and data; that a write strobe appears only with a store; that the halt state is sticky and silent; that the program counter and instruction register change only at their own steps; and that an operand read from register 0 is zero. The data results of loads, stores and adds, the ordering of fetch and data addresses, the wrap of the sum, register 0 ignoring writes, and the L+3 / 2L+3 cycle counts under different memory wait settings are shown only by the bench's program scenarios, which observe the memory bus.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_AW = 5;
  localparam int REG_COUNT = 1 << REG_AW;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] FN_ADD   = 6'h20;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_MEM,
    ST_WB,
    ST_HALT
  } coreState_t;

  typedef struct packed {
    logic addrSelMar;
    logic irLoad;
    logic opLoad;
    logic aluSrcImm;
    logic marLoad;
    logic resLoad;
    logic mdrLoad;
    logic regWrite;
    logic wbSelMem;
    logic pcInc;
  } ctrlStrobes_t;
endpackage

// File: rtl/mcRegFile.sv
module mcRegFile
  import mcp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] rdAddrA,
  input  logic [REG_AW-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  logic [REG_COUNT-1:0][DATA_W-1:0] regs;

  // Entry 0 is never written, so it keeps its reset value of zero.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];
endmodule

// File: rtl/mcDatapath.sv
module mcDatapath
  import mcp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctrl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [5:0]        opcode,
  output logic [5:0]        funct
);
  localparam int IMM_W = 16;
  localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(4);

  logic [DATA_W-1:0] pc, mar, aReg, bReg, resReg, mdr;
  logic [INSTR_W-1:0] ir;
  logic [REG_AW-1:0] rsField, rtField, rdField, wrAddr;
  logic [IMM_W-1:0] immField;
  logic [DATA_W-1:0] immExt, aluB, aluSum, rdA, rdB, wrData;

  assign opcode   = ir[31:26];
  assign rsField  = ir[25:21];
  assign rtField  = ir[20:16];
  assign rdField  = ir[15:11];
  assign immField = ir[15:0];
  assign funct    = ir[5:0];

  assign immExt = {{(DATA_W-IMM_W){immField[IMM_W-1]}}, immField};
  assign aluB   = ctrl.aluSrcImm ? immExt : bReg;
  assign aluSum = aReg + aluB;

  assign wrAddr = ctrl.wbSelMem ? rtField : rdField;
  assign wrData = ctrl.wbSelMem ? mdr : resReg;

  mcRegFile #(.DATA_W(DATA_W)) i_regFile (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rsField), .rdAddrB(rtField),
    .rdDataA(rdA), .rdDataB(rdB),
    .wrEn(ctrl.regWrite), .wrAddr(wrAddr), .wrData(wrData)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= RESET_PC;
      ir     <= '0;
      aReg   <= '0;
      bReg   <= '0;
      mar    <= '0;
      resReg <= '0;
      mdr    <= '0;
    end else begin
      if (ctrl.irLoad)  ir <= memRdata;
      if (ctrl.opLoad) begin
        aReg <= rdA;
        bReg <= rdB;
      end
      if (ctrl.marLoad) mar    <= aluSum;
      if (ctrl.resLoad) resReg <= aluSum;
      if (ctrl.mdrLoad) mdr    <= memRdata;
      if (ctrl.pcInc)   pc     <= pc + PC_STEP;
    end
  end

  assign memAddr  = ctrl.addrSelMar ? mar : pc;
  assign memWdata = bReg;

  // R9
  zero_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.opLoad && rsField == '0) |=> (aReg == '0));

  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.pcInc |=> $stable(pc));

  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.irLoad |=> $stable(ir));
endmodule

// File: rtl/mcControl.sv
module mcControl
  import mcp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [5:0]   opcode,
  input  logic [5:0]   funct,
  input  logic         memReady,
  output ctrlStrobes_t ctrl,
  output logic         memReq,
  output logic         memWe,
  output logic         illegal
);
  coreState_t state, stateNext;
  logic isLoad, isStore, isAdd, isLegal;

  assign isLoad  = (opcode == OP_LOAD);
  assign isStore = (opcode == OP_STORE);
  assign isAdd   = (opcode == OP_RTYPE) && (funct == FN_ADD);
  assign isLegal = isLoad || isStore || isAdd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl      = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    stateNext = state;
    unique case (state)
      ST_FETCH: begin
        memReq      = 1'b1;
        ctrl.irLoad = memReady;
        if (memReady) stateNext = ST_DECODE;
      end
      ST_DECODE: begin
        ctrl.opLoad = 1'b1;
        stateNext   = isLegal ? ST_EXEC : ST_HALT;
      end
      ST_EXEC: begin
        if (isAdd) begin
          ctrl.resLoad = 1'b1;
          stateNext    = ST_WB;
        end else begin
          ctrl.aluSrcImm = 1'b1;
          ctrl.marLoad   = 1'b1;
          stateNext      = ST_MEM;
        end
      end
      ST_MEM: begin
        memReq          = 1'b1;
        memWe           = isStore;
        ctrl.addrSelMar = 1'b1;
        ctrl.mdrLoad    = memReady && isLoad;
        if (memReady) stateNext = ST_WB;
      end
      ST_WB: begin
        ctrl.pcInc    = 1'b1;
        ctrl.regWrite = !isStore;
        ctrl.wbSelMem = isLoad;
        stateNext     = ST_FETCH;
      end
      default: begin
        stateNext = ST_HALT;
      end
    endcase
  end

  assign illegal = (state == ST_HALT);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> (illegal && !memReq));

  // R3
  we_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memReq && opcode == OP_STORE));

  // R8
  decode_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECODE) |=> (state != ST_DECODE));
endmodule

// File: rtl/mcProcCore.sv
module mcProcCore
  import mcp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic              illegal
);
  ctrlStrobes_t ctrl;
  logic [5:0] opcode, funct;

  mcControl i_control (
    .clk(clk), .rstN(rstN),
    .opcode(opcode), .funct(funct), .memReady(memReady),
    .ctrl(ctrl), .memReq(memReq), .memWe(memWe), .illegal(illegal)
  );

  mcDatapath #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .opcode(opcode), .funct(funct)
  );

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=>
      (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R7
  fetch_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !ctrl.addrSelMar) |-> (memAddr[1:0] == 2'b00 && !memWe));
endmodule

// File: tb/test_mcProcCore.sv
`timescale 1ns/1ps
module test_mcProcCore;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memReq, memWe, memReady, illegal;
  logic [31:0] memAddr, memWdata, memRdata;

  always #2.5 clk = ~clk;

  mcProcCore i_mcProcCore (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .illegal(illegal)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int waitCfg = 0;
  int cnt = 0;
  int stableErr = 0;
  int accN = 0;
  logic prevReq = 1'b0;
  logic [31:0] progWord [128];
  logic [31:0] mem [128];
  logic [31:0] accAddr [64];
  logic        accWe [64];
  int          accCyc [64];

  initial begin
    memReady = 1'b0;
    memRdata = '0;
  end

  // memory model: preload during reset, answer after waitCfg extra cycles
  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) mem[i] = progWord[i];
      memReady = 1'b0;
      cnt = 0;
      prevReq = 1'b0;
      accN = 0;
      stableErr = 0;
    end else begin
      if (memReady) begin
        memReady = 1'b0;
        cnt = 0;
      end else if (memReq) begin
        if (!prevReq && accN < 64) begin
          accAddr[accN] = memAddr;
          accWe[accN] = memWe;
          accCyc[accN] = cyc;
          accN++;
        end
        if (cnt == waitCfg) begin
          if (accN > 0 && memAddr !== accAddr[accN-1]) stableErr++;
          memReady = 1'b1;
          if (memWe) mem[memAddr[8:2]] = memWdata;
          else       memRdata = mem[memAddr[8:2]];
        end else begin
          cnt++;
        end
      end
      prevReq = memReq;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      nFail++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] encI(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] encR(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'h00, fn};
  endfunction

  task automatic doReset();
    @(negedge clk);
    #1 rstN = 1'b0;
    @(negedge clk);
    chk("R1", "illegal during reset", {31'b0, illegal}, 32'h0);
    @(negedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic runUntilHalt();
    int k;
    for (k = 0; k < 3000 && illegal !== 1'b1; k++) @(negedge clk);
    chk("R10", "halt reached", {31'b0, illegal}, 32'h1);
  endtask

  task automatic loadProg1();
    for (int i = 0; i < 128; i++) progWord[i] = 32'h0;
    progWord[0] = encI(6'h23, 5'd0, 5'd2, 16'h0100);
    progWord[1] = 32'h8C410000;
    progWord[2] = encI(6'h23, 5'd0, 5'd3, 16'h0104);
    progWord[3] = 32'h00232020;
    progWord[4] = encI(6'h2B, 5'd0, 5'd4, 16'h0108);
    progWord[5] = encR(5'd2, 5'd2, 5'd5, 6'h20);
    progWord[6] = encI(6'h2B, 5'd2, 5'd5, 16'hFFFC);
    progWord[7] = 32'hFC000000;
    progWord[16] = 32'h11112222;
    progWord[64] = 32'h00000040;
    progWord[65] = 32'hF3334444;
  endtask

  function automatic logic [31:0] expAddr1(input int i);
    case (i)
      0: return 32'h0;    1: return 32'h100; 2: return 32'h4;   3: return 32'h40;
      4: return 32'h8;    5: return 32'h104; 6: return 32'hC;   7: return 32'h10;
      8: return 32'h108;  9: return 32'h14;  10: return 32'h18; 11: return 32'h3C;
      default: return 32'h1C;
    endcase
  endfunction

  task automatic testReset();
    loadProg1();
    doReset();
    @(negedge clk);
    chk("R1", "first request", {31'b0, memReq}, 32'h1);
    chk("R1", "first address", memAddr, 32'h0);
    chk("R1", "first strobe", {31'b0, memWe}, 32'h0);
    chk("R1", "illegal after reset", {31'b0, illegal}, 32'h0);
  endtask

  task automatic testProgram(input int w);
    int fIdx [8];
    int lat;
    loadProg1();
    waitCfg = w;
    lat = w + 1;
    doReset();
    runUntilHalt();
    chk("R2", "access count", accN, 13);
    for (int i = 0; i < 13; i++) begin
      chk("R7", "access address order", accAddr[i], expAddr1(i));
      chk("R3", "write strobe only on store",
          {31'b0, accWe[i]}, {31'b0, (i == 8 || i == 11)});
    end
    chk("R3", "request held stable", stableErr, 0);
    chk("R6", "add result stored", mem[66], 32'h0444_6666);
    chk("R4", "load via register base", mem[66] - 32'hF3334444, 32'h11112222);
    chk("R5", "negative offset store, rs equals rt", mem[15], 32'h80);
    fIdx = '{0, 2, 4, 6, 7, 9, 10, 12};
    for (int k = 0; k < 7; k++) begin
      int expGap;
      expGap = (k == 3 || k == 5) ? lat + 3 : 2 * lat + 3;
      chk("R8", "fetch-to-fetch cycles", accCyc[fIdx[k+1]] - accCyc[fIdx[k]], expGap);
    end
  endtask

  task automatic testZeroRegAndFunct();
    int k;
    for (int i = 0; i < 128; i++) progWord[i] = 32'h0;
    progWord[0] = encI(6'h2B, 5'd0, 5'd4, 16'h0118);
    progWord[1] = encI(6'h23, 5'd0, 5'd2, 16'h0100);
    progWord[2] = encI(6'h23, 5'd0, 5'd0, 16'h0100);
    progWord[3] = encR(5'd2, 5'd2, 5'd0, 6'h20);
    progWord[4] = encI(6'h2B, 5'd0, 5'd0, 16'h010C);
    progWord[5] = encR(5'd0, 5'd2, 5'd6, 6'h20);
    progWord[6] = encI(6'h2B, 5'd0, 5'd6, 16'h0110);
    progWord[7] = encR(5'd2, 5'd2, 5'd7, 6'h22);
    progWord[8] = encI(6'h2B, 5'd0, 5'd2, 16'h0114);
    progWord[64] = 32'h40;
    progWord[67] = 32'hDEADBEEF;
    progWord[69] = 32'h00005555;
    progWord[70] = 32'h00000077;
    waitCfg = 1;
    doReset();
    runUntilHalt();
    chk("R1", "registers cleared by reset", mem[70], 32'h0);
    chk("R9", "register 0 ignores writes", mem[67], 32'h0);
    chk("R9", "register 0 reads zero as operand", mem[68], 32'h40);
    chk("R10", "bad funct is last access", accAddr[accN-1], 32'h1C);
    chk("R10", "access count up to bad word", accN, 13);
    for (k = 0; k < 30; k++) begin
      @(negedge clk);
      if (memReq !== 1'b0 || illegal !== 1'b1) break;
    end
    chk("R10", "silent while halted", k, 30);
    chk("R10", "later store not executed", mem[69], 32'h00005555);
    doReset();
    @(negedge clk);
    chk("R10", "reset leaves halt", {31'b0, illegal}, 32'h0);
    chk("R1", "refetch from reset address", memAddr, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) progWord[i] = 32'h0;
    testReset();
    testProgram(0);
    testProgram(2);
    testProgram(4);
    testZeroRegAndFunct();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule